// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment:offset pair into a 20-bit physical address. The segment value is moved up by four bit positions, which is the same as multiplying it by 16, and the offset is added to the result. Any carry out of the top bit is dropped. The block holds four segment registers: code, data, extra and stack. It also holds five pointer registers: instruction pointer, stack pointer, base pointer, string source index and string destination index. Both register sets are loaded through simple write ports.

Each access request carries a kind code. The block picks the segment that is the default for that kind. An optional override may replace that segment, but only for the kinds that allow it. The block also picks the matching offset and drives the physical address combinationally in the same cycle.

String accesses also advance the index register they use once the access is accepted. The step is one for byte elements and two for word elements. The direction flag decides whether the index counts up or down.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals segment value times 16 plus offset, taken modulo 2^20 (segment FFFF with offset FFFF gives 0FFEF).
- R2: Request kind 0 (fetch) uses the code segment with the instruction pointer. The override input has no effect on this kind.
- R3: Request kinds 1 (stack pointer) and 2 (base pointer) use the stack segment by default, with the stack pointer or base pointer as the offset.
- R4: Request kind 4 (string destination) uses the extra segment with the destination index. The override input has no effect on this kind.
- R5: Request kind 3 (string source) uses the data segment with the source index. Kinds 5 to 7 (data) use the data segment with `req_offset`.
- R6: When `ovr_valid` is 1, `ovr_seg` replaces the segment for kinds 1, 2, 3 and 5 to 7. Segment codes are 0 code, 1 data, 2 extra and 3 stack, and `seg_wsel` uses the same codes. `seg_used` reports the code of the segment selected.
- R7: On the clock edge after an accepted request of kind 3, the source index changes by 1 (`elem_word`=0) or 2 (`elem_word`=1). It goes up when `dir_flag`=0 and down when `dir_flag`=1, wrapping modulo 2^16. A request of kind 4 steps the destination index in the same way.
- R8: The address of a string access uses the index value from before that access's update.
- R9: The source and destination indices keep their values when no string access of their kind is accepted and no write targets them.
- R10: `ptr_wsel` codes are 0 instruction pointer, 1 stack pointer, 2 base pointer, 3 source index and 4 destination index. A pointer write takes effect on the next edge. If a write and a string step hit the same index register in the same cycle, the write wins.
- R11: After reset, all segment and pointer registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write |
| seg_wdata | input | 16 | Segment write value |
| ptr_we | input | 1 | Pointer register write enable |
| ptr_wsel | input | 3 | Pointer register to write |
| ptr_wdata | input | 16 | Pointer write value |
| req_valid | input | 1 | Access request accepted this cycle |
| req_kind | input | 3 | Access kind code |
| req_offset | input | 16 | Offset for data kinds |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| dir_flag | input | 1 | 0 steps indices up, 1 steps them down |
| elem_word | input | 1 | 0 byte element, 1 word element |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Code of the segment selected |
| si_val | output | 16 | Current source index |
| di_val | output | 16 | Current destination index |

## Verification
The assertions assume that `req_kind`, `ovr_seg`, `dir_flag` and `elem_word` are valid, non-X values on every clock edge after reset, and that `ptr_wsel` values above 4 write nothing. The bench drives every input from time zero. Random stimulus covers every kind code, including the unused codes 6 and 7, and pointer select codes up to 7, so writes to no register are included. Directed cases set up the address wrap, the index wrap below zero and the collision between a write and a step.

// File: rtl/sag_pkg.sv
package sag_pkg;
   localparam int NUM_SEG = 4;
   localparam int NUM_PTR = 5;

   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_EXTRA = 2'd2,
      SEG_STACK = 2'd3
   } seg_id_e;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_SPTR  = 3'd1,
      K_BPTR  = 3'd2,
      K_SRC   = 3'd3,
      K_DST   = 3'd4,
      K_DATA  = 3'd5
   } acc_kind_e;

   typedef enum logic [2:0] {
      P_IP = 3'd0,
      P_SP = 3'd1,
      P_BP = 3'd2,
      P_SI = 3'd3,
      P_DI = 3'd4
   } ptr_id_e;
endpackage

// File: rtl/sag_seg_file.sv
module sag_seg_file #(
   parameter int SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       wsel,
   input  logic [SEG_W-1:0] wdata,
   input  logic [1:0]       rsel,
   output logic [SEG_W-1:0] rdata
);
   logic [SEG_W-1:0] seg_q [sag_pkg::NUM_SEG];

   for (genvar g = 0; g < sag_pkg::NUM_SEG; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[g] <= '0;
         else if (we && (wsel == 2'(g)))
            seg_q[g] <= wdata;
      end
   end

   assign rdata = seg_q[rsel];
endmodule

// File: rtl/sag_seg_select.sv
module sag_seg_select
   import sag_pkg::*;
(
   input  logic [2:0] kind,
   input  logic       ovr_valid,
   input  logic [1:0] ovr_seg,
   output logic [1:0] seg_sel
);
   logic [1:0] dflt;
   logic       locked;

   always_comb begin
      locked = 1'b0;
      case (kind)
         K_FETCH: begin dflt = SEG_CODE;  locked = 1'b1; end
         K_SPTR,
         K_BPTR:  dflt = SEG_STACK;
         K_DST:   begin dflt = SEG_EXTRA; locked = 1'b1; end
         default: dflt = SEG_DATA;
      endcase
      seg_sel = (ovr_valid && !locked) ? ovr_seg : dflt;
   end
endmodule

// File: rtl/sag_ptr_file.sv
module sag_ptr_file
   import sag_pkg::*;
#(
   parameter int OFF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       wsel,
   input  logic [OFF_W-1:0] wdata,
   input  logic             step_src,
   input  logic             step_dst,
   input  logic             dir_down,
   input  logic             word,
   output logic [OFF_W-1:0] ptr_o [NUM_PTR]
);
   localparam logic [OFF_W-1:0] STEP_B = OFF_W'(1);
   localparam logic [OFF_W-1:0] STEP_W = OFF_W'(2);

   logic [OFF_W-1:0] step;
   logic [OFF_W-1:0] ptr_q [NUM_PTR];

   assign step = word ? STEP_W : STEP_B;

   for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
      logic adv;
      if (g == int'(P_SI)) begin : g_src
         assign adv = step_src;
      end else if (g == int'(P_DI)) begin : g_dst
         assign adv = step_dst;
      end else begin : g_fixed
         assign adv = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr_q[g] <= '0;
         else if (we && (wsel == 3'(g)))
            ptr_q[g] <= wdata;
         else if (adv)
            ptr_q[g] <= dir_down ? (ptr_q[g] - step) : (ptr_q[g] + step);
      end

      assign ptr_o[g] = ptr_q[g];
   end
endmodule

// File: rtl/sag_addr_add.sv
module sag_addr_add #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);
   localparam int BASE_W = SEG_W + SHIFT;
   localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

   logic [SUM_W-1:0] base_ext;
   logic [SUM_W-1:0] off_ext;
   logic [SUM_W-1:0] sum;

   assign base_ext = SUM_W'({seg, {SHIFT{1'b0}}});
   assign off_ext  = SUM_W'(off);
   assign sum      = base_ext + off_ext;

   if (SUM_W > ADDR_W) begin : g_trunc
      assign addr = sum[ADDR_W-1:0];
   end else begin : g_widen
      assign addr = ADDR_W'(sum);
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import sag_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   localparam int ADDR_W = SEG_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_we,
   input  logic [1:0]        seg_wsel,
   input  logic [SEG_W-1:0]  seg_wdata,
   input  logic              ptr_we,
   input  logic [2:0]        ptr_wsel,
   input  logic [OFF_W-1:0]  ptr_wdata,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic              ovr_valid,
   input  logic [1:0]        ovr_seg,
   input  logic              dir_flag,
   input  logic              elem_word,
   output logic [ADDR_W-1:0] phys_addr,
   output logic [1:0]        seg_used,
   output logic [OFF_W-1:0]  si_val,
   output logic [OFF_W-1:0]  di_val
);
   if (SEG_W < 1 || OFF_W < 2 || SHIFT < 0) begin : g_bad_width
      $error("seg_addr_gen: illegal width parameters");
   end
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("seg_addr_gen: offset wider than address");
   end

   logic [SEG_W-1:0] seg_val;
   logic [OFF_W-1:0] off_val;
   logic [OFF_W-1:0] ptrs [NUM_PTR];
   logic             step_src;
   logic             step_dst;

   assign step_src = req_valid && (req_kind == K_SRC);
   assign step_dst = req_valid && (req_kind == K_DST);

   sag_seg_select u_sel (
      .kind      (req_kind),
      .ovr_valid (ovr_valid),
      .ovr_seg   (ovr_seg),
      .seg_sel   (seg_used)
   );

   sag_seg_file #(.SEG_W(SEG_W)) u_segs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (seg_we),
      .wsel  (seg_wsel),
      .wdata (seg_wdata),
      .rsel  (seg_used),
      .rdata (seg_val)
   );

   sag_ptr_file #(.OFF_W(OFF_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ptr_we),
      .wsel     (ptr_wsel),
      .wdata    (ptr_wdata),
      .step_src (step_src),
      .step_dst (step_dst),
      .dir_down (dir_flag),
      .word     (elem_word),
      .ptr_o    (ptrs)
   );

   always_comb begin
      case (req_kind)
         K_FETCH: off_val = ptrs[P_IP];
         K_SPTR:  off_val = ptrs[P_SP];
         K_BPTR:  off_val = ptrs[P_BP];
         K_SRC:   off_val = ptrs[P_SI];
         K_DST:   off_val = ptrs[P_DI];
         default: off_val = req_offset;
      endcase
   end

   sag_addr_add #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
   ) u_add (
      .seg  (seg_val),
      .off  (off_val),
      .addr (phys_addr)
   );

   assign si_val = ptrs[P_SI];
   assign di_val = ptrs[P_DI];
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
   parameter int OFF_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       req_kind,
   input logic             ovr_valid,
   input logic [1:0]       ovr_seg,
   input logic             ptr_we,
   input logic [2:0]       ptr_wsel,
   input logic [OFF_W-1:0] ptr_wdata,
   input logic             dir_flag,
   input logic             elem_word,
   input logic [1:0]       seg_used,
   input logic [OFF_W-1:0] si_val,
   input logic [OFF_W-1:0] di_val
);
   logic [OFF_W-1:0] stp;
   assign stp = elem_word ? OFF_W'(2) : OFF_W'(1);

   // R2
   a_r2_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 3'd0 |-> seg_used == 2'd0);
   // R4
   a_r4_dst_extra: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 3'd4 |-> seg_used == 2'd2);
   // R3
   a_r3_stack_default: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !ovr_valid && (req_kind == 3'd1 || req_kind == 3'd2)
      |-> seg_used == 2'd3);
   // R6
   a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && ovr_valid && req_kind != 3'd0 && req_kind != 3'd4
      |-> seg_used == ovr_seg);
   // R7
   a_r7_src_step: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 3'd3 && !(ptr_we && ptr_wsel == 3'd3)
      |=> si_val == ($past(dir_flag) ? $past(si_val) - $past(stp)
                                     : $past(si_val) + $past(stp)));
   // R7
   a_r7_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 3'd4 && !(ptr_we && ptr_wsel == 3'd4)
      |=> di_val == ($past(dir_flag) ? $past(di_val) - $past(stp)
                                     : $past(di_val) + $past(stp)));
   // R9
   a_r9_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_kind == 3'd3) && !(ptr_we && ptr_wsel == 3'd3)
      |=> $stable(si_val));
   // R9
   a_r9_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_kind == 3'd4) && !(ptr_we && ptr_wsel == 3'd4)
      |=> $stable(di_val));
   // R10
   a_r10_src_write: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we && ptr_wsel == 3'd3 |=> si_val == $past(ptr_wdata));
   // R10
   a_r10_dst_write: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we && ptr_wsel == 3'd4 |=> di_val == $past(ptr_wdata));
endmodule

bind seg_addr_gen sag_checker #(.OFF_W(OFF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .ovr_valid (ovr_valid),
   .ovr_seg   (ovr_seg),
   .ptr_we    (ptr_we),
   .ptr_wsel  (ptr_wsel),
   .ptr_wdata (ptr_wdata),
   .dir_flag  (dir_flag),
   .elem_word (elem_word),
   .seg_used  (seg_used),
   .si_val    (si_val),
   .di_val    (di_val)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_we = 1'b0;
   logic [1:0]  seg_wsel = '0;
   logic [15:0] seg_wdata = '0;
   logic        ptr_we = 1'b0;
   logic [2:0]  ptr_wsel = '0;
   logic [15:0] ptr_wdata = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = '0;
   logic [15:0] req_offset = '0;
   logic        ovr_valid = 1'b0;
   logic [1:0]  ovr_seg = '0;
   logic        dir_flag = 1'b0;
   logic        elem_word = 1'b0;
   logic [19:0] phys_addr;
   logic [1:0]  seg_used;
   logic [15:0] si_val;
   logic [15:0] di_val;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [15:0] m_seg [4];
   logic [15:0] m_ptr [5];

   always #2 clk = ~clk;

   seg_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
      .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wdata(ptr_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
      .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
      .dir_flag(dir_flag), .elem_word(elem_word),
      .phys_addr(phys_addr), .seg_used(seg_used),
      .si_val(si_val), .di_val(di_val)
   );

   function automatic logic [1:0] exp_seg(logic [2:0] k, logic ov, logic [1:0] os);
      if (k == 3'd0) return 2'd0;
      if (k == 3'd4) return 2'd2;
      if (ov) return os;
      if (k == 3'd1 || k == 3'd2) return 2'd3;
      return 2'd1;
   endfunction

   function automatic logic [15:0] exp_off(logic [2:0] k, logic [15:0] ro);
      case (k)
         3'd0: return m_ptr[0];
         3'd1: return m_ptr[1];
         3'd2: return m_ptr[2];
         3'd3: return m_ptr[3];
         3'd4: return m_ptr[4];
         default: return ro;
      endcase
   endfunction

   function automatic logic [19:0] exp_addr(logic [15:0] s, logic [15:0] o);
      logic [23:0] full;
      full = {4'h0, s, 4'h0} + {8'h0, o};
      return full[19:0];
   endfunction

   function automatic logic [15:0] stepped(logic [15:0] v, logic d, logic w);
      logic [15:0] s;
      s = w ? 16'd2 : 16'd1;
      return d ? v - s : v + s;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string kind_tag(logic [2:0] k, logic ov);
      case (k)
         3'd0: return "R1 R2";
         3'd1, 3'd2: return ov ? "R1 R6" : "R1 R3";
         3'd3: return ov ? "R6 R8" : "R5 R8";
         3'd4: return "R4 R8";
         default: return ov ? "R1 R6" : "R1 R5";
      endcase
   endfunction

   // Called right after a falling edge, with inputs already driven.
   task automatic run_cycle();
      logic [1:0]  es;
      logic        src_go;
      logic        dst_go;
      #1;
      if (req_valid) begin
         es = exp_seg(req_kind, ovr_valid, ovr_seg);
         check(kind_tag(req_kind, ovr_valid), 32'(seg_used), 32'(es));
         check(kind_tag(req_kind, ovr_valid), 32'(phys_addr),
               32'(exp_addr(m_seg[es], exp_off(req_kind, req_offset))));
      end
      src_go = req_valid && req_kind == 3'd3;
      dst_go = req_valid && req_kind == 3'd4;
      @(posedge clk);
      if (src_go) m_ptr[3] = stepped(m_ptr[3], dir_flag, elem_word);
      if (dst_go) m_ptr[4] = stepped(m_ptr[4], dir_flag, elem_word);
      if (ptr_we && ptr_wsel <= 3'd4) m_ptr[ptr_wsel] = ptr_wdata;
      if (seg_we) m_seg[seg_wsel] = seg_wdata;
      @(negedge clk);
      check(src_go ? "R7 R10 src" : "R9 R10 src", 32'(si_val), 32'(m_ptr[3]));
      check(dst_go ? "R7 R10 dst" : "R9 R10 dst", 32'(di_val), 32'(m_ptr[4]));
   endtask

   task automatic idle_inputs();
      seg_we = 0; ptr_we = 0; req_valid = 0; ovr_valid = 0;
   endtask

   task automatic wseg(logic [1:0] s, logic [15:0] v);
      idle_inputs(); seg_we = 1; seg_wsel = s; seg_wdata = v; run_cycle();
   endtask

   task automatic wptr(logic [2:0] p, logic [15:0] v);
      idle_inputs(); ptr_we = 1; ptr_wsel = p; ptr_wdata = v; run_cycle();
   endtask

   task automatic req(logic [2:0] k, logic [15:0] o, logic ov, logic [1:0] os,
                      logic d, logic w);
      idle_inputs(); req_valid = 1; req_kind = k; req_offset = o;
      ovr_valid = ov; ovr_seg = os; dir_flag = d; elem_word = w; run_cycle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   initial begin
      int seed;
      seed = 32'h5A6D;
      void'($urandom(seed));
      for (int i = 0; i < 4; i++) m_seg[i] = '0;
      for (int i = 0; i < 5; i++) m_ptr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 si", 32'(si_val), 32'h0);
      check("R11 di", 32'(di_val), 32'h0);
      req_valid = 1; req_kind = 3'd0; #1;
      check("R11 fetch addr", 32'(phys_addr), 32'h0);
      req_valid = 0;
      @(negedge clk);

      // R1 wrap: data segment FFFF plus offset FFFF
      wseg(2'd1, 16'hFFFF);
      req(3'd5, 16'hFFFF, 0, 2'd0, 0, 0);
      // R2 fetch with override present
      wseg(2'd0, 16'h1234);
      wptr(3'd0, 16'h0010);
      req(3'd0, 16'h0, 1, 2'd3, 0, 0);
      // R3 stack default, R6 override on stack
      wseg(2'd3, 16'h8000);
      wptr(3'd1, 16'hFFFE);
      req(3'd1, 16'h0, 0, 2'd0, 0, 0);
      req(3'd2, 16'h0, 1, 2'd2, 0, 0);
      // R4 dest ignores override; R7 word increment
      wseg(2'd2, 16'h0B00);
      wptr(3'd4, 16'h0100);
      req(3'd4, 16'h0, 1, 2'd1, 0, 1);
      req(3'd4, 16'h0, 0, 2'd0, 0, 1);
      // R7 wrap below zero on source index, R8 pre-update address
      wptr(3'd3, 16'h0000);
      req(3'd3, 16'h0, 0, 2'd0, 1, 1);
      req(3'd3, 16'h0, 0, 2'd0, 1, 0);
      // R10 write wins over step
      idle_inputs(); req_valid = 1; req_kind = 3'd3; dir_flag = 0; elem_word = 1;
      ptr_we = 1; ptr_wsel = 3'd3; ptr_wdata = 16'h4321; run_cycle();
      check("R10 write wins", 32'(si_val), 32'h4321);

      for (int n = 0; n < 3000; n++) begin
         seg_we    = ($urandom % 5) == 0;
         seg_wsel  = 2'($urandom);
         seg_wdata = 16'($urandom);
         ptr_we    = ($urandom % 5) == 0;
         ptr_wsel  = 3'($urandom);
         ptr_wdata = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
         req_valid = ($urandom % 4) != 0;
         req_kind  = 3'($urandom);
         req_offset = 16'($urandom);
         ovr_valid = ($urandom % 3) == 0;
         ovr_seg   = 2'($urandom);
         dir_flag  = 1'($urandom);
         elem_word = 1'($urandom);
         run_cycle();
      end
      idle_inputs();
      finish_run();
   end
endmodule